// File: doc/BRIEF.md
# Tagged Translation Lookaside Buffer

This block is a small, fully associative store of address translations. Each entry maps a virtual page number to a physical frame number. It also holds permission bits, an address-space tag, a global flag and one of three page sizes (4 KiB, 2 MiB or 1 GiB). A lookup gives hit, physical address and permissions combinationally, in the same cycle. A miss is flagged so that a page walker outside the block can fetch the translation. The walker then installs the result through the fill port.

Because each entry carries an address-space tag, translations from several address spaces can be held at once. Entries marked global match under any tag. A maintenance port keeps the cached copy consistent with the page tables. It takes three commands: invalidate the translations that cover one address, drop every non-global entry (the effect of a context load), or drop everything.

Top module: `tagged_tlb`

## Requirements
- R1: After reset every entry is invalid and every lookup misses.
- R2: In a cycle with `lk_valid` high, `lk_hit` and `lk_miss` are combinational and exactly one of them is high. On a hit, `lk_pa` and `lk_perm` come from the matching entry in that same cycle. With `lk_valid` low, both flags are low.
- R3: A non-global entry matches only when its stored tag equals `lk_asid`. Entries that share a virtual page but have different tags coexist, and each returns its own frame.
- R4: A global entry matches under any `lk_asid`.
- R5: The page-size codes are 00 = 4 KiB, 01 = 2 MiB, 10 or 11 = 1 GiB. Matching compares only the virtual address bits above the entry's page offset (bit 12, 21 or 30 and up). On a hit, `lk_pa` takes the frame bits above that offset and the virtual address bits below it.
- R6: A fill matches an existing valid entry when the page size, the global flag and the page number above the offset are all equal, and the tag is also equal for non-global entries. Such a fill overwrites that entry and does not move the replacement pointer.
- R7: Any other fill writes the slot under a round-robin pointer that starts at 0 after reset and steps by one per allocation over 16 entries. The 17th distinct fill therefore evicts the first.
- R8: Maintenance command 01 removes every entry whose page covers `mt_va`, whatever its tag and whether it is global or not.
- R9: Maintenance command 10 removes all non-global entries and keeps all global entries. Command 00 does nothing.
- R10: Maintenance command 11 removes all entries.
- R11: A maintenance command is applied before the lookup of the same cycle, so that lookup cannot hit an entry being removed. A fill in the same cycle is written after the command, and it keeps its slot.
- R12: When several entries match a lookup, the lowest-index entry supplies the result.
- R13: A lookup in the same cycle as a fill sees the contents from before the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_asid | input | 12 | Address-space tag of the lookup |
| lk_va | input | 48 | Virtual address to translate |
| lk_hit | output | 1 | Lookup found a translation |
| lk_miss | output | 1 | Lookup found none; walker must run |
| lk_pa | output | 52 | Translated physical address (zero on miss) |
| lk_perm | output | 4 | Stored permission bits of the hit |
| lk_size | output | 2 | Page-size code of the hit |
| lk_global | output | 1 | Global flag of the hit |
| fl_valid | input | 1 | Fill request |
| fl_asid | input | 12 | Tag of the new entry |
| fl_vpn | input | 36 | Virtual page number (address bits 47:12) |
| fl_pfn | input | 40 | Physical frame number (address bits 51:12) |
| fl_perm | input | 4 | Permission bits |
| fl_size | input | 2 | Page-size code |
| fl_global | input | 1 | Global flag |
| mt_valid | input | 1 | Maintenance request |
| mt_cmd | input | 2 | 01 page, 10 non-global, 11 all |
| mt_va | input | 48 | Address for the page command |

## Verification
The hardest situation to reach is one where several valid entries match the same lookup. Overwrite-on-fill prevents exact duplicates, so overlap only arises across page sizes or between a global and a tagged entry. The stimulus creates it by installing a 2 MiB page and 4 KiB pages inside it, in both fill orders, and then checks which frame is returned before and after a page invalidate. A second hard case is the interaction of commands in one cycle. Lookup plus invalidate, and fill plus flush, are driven together so that the ordering within the cycle is visible at the ports.

// File: rtl/tagged_tlb_pkg.sv
package tagged_tlb_pkg;

  typedef enum logic [1:0] {
    PG_4K = 2'b00,
    PG_2M = 2'b01,
    PG_1G = 2'b10
  } pg_size_e;

  typedef enum logic [1:0] {
    MT_NOP  = 2'b00,
    MT_PAGE = 2'b01,
    MT_CTX  = 2'b10,
    MT_ALL  = 2'b11
  } mt_cmd_e;

  localparam int BASE_OFS = 12;

  // number of untranslated low address bits for a size code
  function automatic int ofs_bits(input logic [1:0] sz);
    case (sz)
      2'b00:   return 12;
      2'b01:   return 21;
      default: return 30;
    endcase
  endfunction

endpackage

// File: rtl/tlb_tag_cmp.sv
module tlb_tag_cmp
  import tagged_tlb_pkg::*;
#(
  parameter int VPN_W = 36,
  parameter int TAG_W = 12
) (
  input  logic             e_valid,
  input  logic             e_global,
  input  logic [1:0]       e_size,
  input  logic [VPN_W-1:0] e_vpn,
  input  logic [TAG_W-1:0] e_asid,
  input  logic [VPN_W-1:0] q_vpn,
  input  logic [TAG_W-1:0] q_asid,
  input  logic             any_tag,
  output logic             hit
);

  function automatic logic [VPN_W-1:0] keep_mask(input logic [1:0] sz);
    int s;
    s = ofs_bits(sz) - BASE_OFS;
    return ~((VPN_W'(1) << s) - VPN_W'(1));
  endfunction

  logic tag_ok;
  logic page_ok;

  assign tag_ok  = any_tag || e_global || (e_asid == q_asid);
  assign page_ok = ((e_vpn ^ q_vpn) & keep_mask(e_size)) == '0;
  assign hit     = e_valid && tag_ok && page_ok;

endmodule

// File: rtl/tlb_low_pick.sv
module tlb_low_pick #(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic [N-1:0]     onehot,
  output logic [IDX_W-1:0] idx,
  output logic             any
);

  always_comb begin
    onehot = '0;
    idx    = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        onehot    = '0;
        onehot[i] = 1'b1;
        idx       = IDX_W'(i);
      end
    end
  end

  assign any = |req;

endmodule

// File: rtl/tlb_rr_ptr.sv
module tlb_rr_ptr #(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr <= '0;
    else if (adv) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end

endmodule

// File: rtl/tagged_tlb.sv
module tagged_tlb
  import tagged_tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VA_W    = 48,
  parameter int PA_W    = 52,
  parameter int TAG_W   = 12,
  parameter int PERM_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [TAG_W-1:0]  lk_asid,
  input  logic [VA_W-1:0]   lk_va,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic [PA_W-1:0]   lk_pa,
  output logic [PERM_W-1:0] lk_perm,
  output logic [1:0]        lk_size,
  output logic              lk_global,
  input  logic              fl_valid,
  input  logic [TAG_W-1:0]  fl_asid,
  input  logic [VA_W-13:0]  fl_vpn,
  input  logic [PA_W-13:0]  fl_pfn,
  input  logic [PERM_W-1:0] fl_perm,
  input  logic [1:0]        fl_size,
  input  logic              fl_global,
  input  logic              mt_valid,
  input  logic [1:0]        mt_cmd,
  input  logic [VA_W-1:0]   mt_va
);

  localparam int VPN_W = VA_W - BASE_OFS;
  localparam int PFN_W = PA_W - BASE_OFS;
  localparam int IDX_W = $clog2(ENTRIES);

  // entry storage
  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] glob_q;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [TAG_W-1:0]   asid_q [ENTRIES];
  logic [PFN_W-1:0]   pfn_q  [ENTRIES];
  logic [PERM_W-1:0]  perm_q [ENTRIES];
  logic [1:0]         size_q [ENTRIES];

  // named internal events
  logic [ENTRIES-1:0] lk_raw, lk_req, lk_sel;
  logic [ENTRIES-1:0] mt_cover, kill_vec;
  logic [ENTRIES-1:0] fl_cmp, fl_same, fl_sel;
  logic [IDX_W-1:0]   lk_idx, fl_idx, rr_ptr, wr_idx;
  logic               lk_any, fl_hit_any, rr_adv;

  // frame bits above the page offset, address bits below it
  function automatic logic [PA_W-1:0] make_pa(input logic [PFN_W-1:0] pfn,
                                              input logic [VA_W-1:0]  va,
                                              input logic [1:0]       sz);
    logic [PA_W-1:0] low;
    low = (PA_W'(1) << ofs_bits(sz)) - PA_W'(1);
    return ({pfn, {BASE_OFS{1'b0}}} & ~low) | (PA_W'(va) & low);
  endfunction

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    tlb_tag_cmp #(.VPN_W(VPN_W), .TAG_W(TAG_W)) u_lk (
      .e_valid(valid_q[i]), .e_global(glob_q[i]), .e_size(size_q[i]),
      .e_vpn(vpn_q[i]), .e_asid(asid_q[i]),
      .q_vpn(lk_va[VA_W-1:BASE_OFS]), .q_asid(lk_asid), .any_tag(1'b0),
      .hit(lk_raw[i]));
    tlb_tag_cmp #(.VPN_W(VPN_W), .TAG_W(TAG_W)) u_mt (
      .e_valid(valid_q[i]), .e_global(glob_q[i]), .e_size(size_q[i]),
      .e_vpn(vpn_q[i]), .e_asid(asid_q[i]),
      .q_vpn(mt_va[VA_W-1:BASE_OFS]), .q_asid(lk_asid), .any_tag(1'b1),
      .hit(mt_cover[i]));
    tlb_tag_cmp #(.VPN_W(VPN_W), .TAG_W(TAG_W)) u_fl (
      .e_valid(valid_q[i]), .e_global(glob_q[i]), .e_size(size_q[i]),
      .e_vpn(vpn_q[i]), .e_asid(asid_q[i]),
      .q_vpn(fl_vpn), .q_asid(fl_asid), .any_tag(1'b0),
      .hit(fl_cmp[i]));
    assign fl_same[i] = fl_cmp[i] && (size_q[i] == fl_size) && (glob_q[i] == fl_global);
  end

  // maintenance removals, applied ahead of the same-cycle lookup
  always_comb begin
    kill_vec = '0;
    if (mt_valid) begin
      case (mt_cmd)
        MT_PAGE: kill_vec = mt_cover;
        MT_CTX:  kill_vec = valid_q & ~glob_q;
        MT_ALL:  kill_vec = '1;
        default: kill_vec = '0;
      endcase
    end
  end

  assign lk_req = lk_valid ? (lk_raw & ~kill_vec) : '0;

  tlb_low_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_lk_pick (
    .req(lk_req), .onehot(lk_sel), .idx(lk_idx), .any(lk_any));

  tlb_low_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_fl_pick (
    .req(fl_same), .onehot(fl_sel), .idx(fl_idx), .any(fl_hit_any));

  assign rr_adv = fl_valid && !fl_hit_any;
  assign wr_idx = fl_hit_any ? fl_idx : rr_ptr;

  tlb_rr_ptr #(.N(ENTRIES), .IDX_W(IDX_W)) u_rr (
    .clk(clk), .rst_n(rst_n), .adv(rr_adv), .ptr(rr_ptr));

  assign lk_hit    = lk_any;
  assign lk_miss   = lk_valid && !lk_any;
  assign lk_pa     = lk_any ? make_pa(pfn_q[lk_idx], lk_va, size_q[lk_idx]) : '0;
  assign lk_perm   = lk_any ? perm_q[lk_idx] : '0;
  assign lk_size   = lk_any ? size_q[lk_idx] : 2'b00;
  assign lk_global = lk_any && glob_q[lk_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      valid_q <= valid_q & ~kill_vec;
      if (fl_valid) valid_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fl_valid) begin
      glob_q[wr_idx] <= fl_global;
      vpn_q[wr_idx]  <= fl_vpn;
      asid_q[wr_idx] <= fl_asid;
      pfn_q[wr_idx]  <= fl_pfn;
      perm_q[wr_idx] <= fl_perm;
      size_q[wr_idx] <= fl_size;
    end
  end

endmodule

// File: rtl/tagged_tlb_chk.sv
module tagged_tlb_chk #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_valid,
  input logic               lk_hit,
  input logic               lk_miss,
  input logic               fl_valid,
  input logic               mt_valid,
  input logic [1:0]         mt_cmd,
  input logic [ENTRIES-1:0] valid_vec,
  input logic [ENTRIES-1:0] global_vec,
  input logic [ENTRIES-1:0] lk_sel,
  input logic [ENTRIES-1:0] kill_vec,
  input logic [IDX_W-1:0]   rr_ptr,
  input logic               fl_hit_any
);

  p_hit_xor_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> (lk_hit != lk_miss));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (!lk_hit && !lk_miss));

  p_single_winner_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_sel));

  p_no_hit_on_removed_r11: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> ((lk_sel & kill_vec) == '0));

  p_flush_all_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mt_valid && mt_cmd == 2'b11 && !fl_valid) |=> (valid_vec == '0));

  p_ctx_keeps_global_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mt_valid && mt_cmd == 2'b10 && !fl_valid) |=> (valid_vec == $past(valid_vec & global_vec)));

  p_rr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_valid && !fl_hit_any) |=>
      (rr_ptr == (($past(rr_ptr) == IDX_W'(ENTRIES - 1)) ? '0 : $past(rr_ptr) + 1'b1)));

  p_rr_hold_on_overwrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_valid && fl_hit_any) |=> $stable(rr_ptr));

endmodule

bind tagged_tlb tagged_tlb_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_hit(lk_hit), .lk_miss(lk_miss),
  .fl_valid(fl_valid), .mt_valid(mt_valid), .mt_cmd(mt_cmd),
  .valid_vec(valid_q), .global_vec(glob_q), .lk_sel(lk_sel), .kill_vec(kill_vec),
  .rr_ptr(rr_ptr), .fl_hit_any(fl_hit_any));

// File: tb/tagged_tlb_test.sv
module tagged_tlb_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // stimulus
  logic        s_lv = 0, s_fv = 0, s_mv = 0, s_fg = 0;
  logic [11:0] s_la = 0, s_fa = 0;
  logic [47:0] s_lva = 0, s_mva = 0;
  logic [35:0] s_fvpn = 0;
  logic [39:0] s_fpfn = 0;
  logic [3:0]  s_fperm = 0;
  logic [1:0]  s_fsz = 0, s_mcmd = 0;

  logic        lk_hit, lk_miss, lk_global;
  logic [51:0] lk_pa;
  logic [3:0]  lk_perm;
  logic [1:0]  lk_size;

  tagged_tlb uut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(s_lv), .lk_asid(s_la), .lk_va(s_lva),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_pa(lk_pa), .lk_perm(lk_perm),
    .lk_size(lk_size), .lk_global(lk_global),
    .fl_valid(s_fv), .fl_asid(s_fa), .fl_vpn(s_fvpn), .fl_pfn(s_fpfn),
    .fl_perm(s_fperm), .fl_size(s_fsz), .fl_global(s_fg),
    .mt_valid(s_mv), .mt_cmd(s_mcmd), .mt_va(s_mva));

  // reference contents
  logic        md_v    [N];
  logic        md_g    [N];
  logic [11:0] md_asid [N];
  logic [35:0] md_vpn  [N];
  logic [39:0] md_pfn  [N];
  logic [3:0]  md_perm [N];
  logic [1:0]  md_size [N];
  int md_ptr = 0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  function automatic int pg_shift(input logic [1:0] sz);
    return (sz == 2'b00) ? 0 : (sz == 2'b01) ? 9 : 18;
  endfunction

  function automatic bit same_page(input logic [35:0] a, input logic [35:0] b, input logic [1:0] sz);
    return (a >> pg_shift(sz)) == (b >> pg_shift(sz));
  endfunction

  function automatic logic [15:0] kill_of();
    logic [15:0] k = '0;
    for (int i = 0; i < N; i++) begin
      if (s_mv) begin
        if (s_mcmd == 2'b01) k[i] = md_v[i] && same_page(md_vpn[i], s_mva[47:12], md_size[i]);
        if (s_mcmd == 2'b10) k[i] = md_v[i] && !md_g[i];
        if (s_mcmd == 2'b11) k[i] = md_v[i];
      end
    end
    return k;
  endfunction

  function automatic int fill_slot();
    for (int i = 0; i < N; i++)
      if (md_v[i] && md_size[i] == s_fsz && md_g[i] == s_fg &&
          (s_fg || md_asid[i] == s_fa) && same_page(md_vpn[i], s_fvpn, s_fsz))
        return i;
    return -1;
  endfunction

  task automatic check_look(input string tag, input logic [15:0] k);
    int idx = -1;
    int ob;
    logic [51:0] base, exp_pa;
    for (int i = 0; i < N; i++)
      if (idx < 0 && md_v[i] && !k[i] && (md_g[i] || md_asid[i] == s_la) &&
          same_page(md_vpn[i], s_lva[47:12], md_size[i]))
        idx = i;
    n_chk++;
    if (idx < 0) begin
      if (lk_hit !== 1'b0 || lk_miss !== 1'b1) begin
        n_fail++;
        $display("FAIL %s va=%h asid=%h: hit/miss=%b%b expected 01", tag, s_lva, s_la, lk_hit, lk_miss);
      end
    end else begin
      ob = 12 + pg_shift(md_size[idx]);
      base = {md_pfn[idx], 12'h000};
      exp_pa = ((base >> ob) << ob) | ({4'h0, s_lva} & ((52'd1 << ob) - 52'd1));
      if (lk_hit !== 1'b1 || lk_miss !== 1'b0 || lk_pa !== exp_pa || lk_perm !== md_perm[idx]) begin
        n_fail++;
        $display("FAIL %s va=%h asid=%h: hit=%b pa=%h perm=%h expected hit=1 pa=%h perm=%h",
                 tag, s_lva, s_la, lk_hit, lk_pa, lk_perm, exp_pa, md_perm[idx]);
      end
    end
  endtask

  task automatic step(input string tag);
    logic [15:0] k;
    int fs, slot;
    #1;
    k = kill_of();
    if (s_lv) check_look(tag, k);
    fs = fill_slot();
    @(posedge clk);
    #1;
    for (int i = 0; i < N; i++) if (k[i]) md_v[i] = 1'b0;
    if (s_fv) begin
      slot = (fs >= 0) ? fs : md_ptr;
      md_v[slot] = 1'b1; md_g[slot] = s_fg; md_asid[slot] = s_fa; md_vpn[slot] = s_fvpn;
      md_pfn[slot] = s_fpfn; md_perm[slot] = s_fperm; md_size[slot] = s_fsz;
      if (fs < 0) md_ptr = (md_ptr + 1) % N;
    end
    s_lv = 0; s_fv = 0; s_mv = 0;
  endtask

  task automatic set_fill(input logic [11:0] a, input logic [35:0] vpn, input logic [39:0] pfn,
                          input logic [3:0] perm, input logic [1:0] sz, input logic g);
    s_fv = 1; s_fa = a; s_fvpn = vpn; s_fpfn = pfn; s_fperm = perm; s_fsz = sz; s_fg = g;
  endtask

  task automatic fill(input logic [11:0] a, input logic [35:0] vpn, input logic [39:0] pfn,
                      input logic [3:0] perm, input logic [1:0] sz, input logic g);
    @(negedge clk);
    set_fill(a, vpn, pfn, perm, sz, g);
    step("fill");
  endtask

  task automatic look(input logic [11:0] a, input logic [47:0] va, input string tag);
    @(negedge clk);
    s_lv = 1; s_la = a; s_lva = va;
    step(tag);
  endtask

  task automatic maint(input logic [1:0] cmd, input logic [47:0] va);
    @(negedge clk);
    s_mv = 1; s_mcmd = cmd; s_mva = va;
    step("maint");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < N; i++) md_v[i] = 1'b0;
    md_ptr = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < N; i++) md_v[i] = 1'b0;
    do_reset();

    // R1: empty after reset
    for (int i = 0; i < 4; i++) look(12'(i), 48'(i) << 30, "R1");

    // R2 R3 R4 R5: one entry per 1 GiB region, mixed sizes, tags and global flags
    for (int i = 0; i < N; i++)
      fill(12'(i + 1), 36'(i) << 18, 40'h5_0000_0000 + (40'(i) << 22) + 40'(i * 7),
           4'(i), 2'(i % 3), (i % 5) == 0);
    for (int i = 0; i < N; i++) begin
      logic [47:0] pg, base;
      pg = 48'd1 << (12 + pg_shift(2'(i % 3)));
      base = 48'(i) << 30;
      look(12'(i + 1), base, "R2");
      look(12'(i + 1), base + pg - 1, "R5");
      look(12'(i + 1), base + (48'($urandom) % pg), "R5");
      look(12'(i + 1), base + pg, "R5");
      look(12'(i + 200), base + 48'h123, (i % 5) == 0 ? "R4" : "R3");
    end

    // R3: same page under two tags
    do_reset();
    fill(12'd7, 36'h1234, 40'hAAA, 4'h1, 2'b00, 1'b0);
    fill(12'd8, 36'h1234, 40'hBBB, 4'h2, 2'b00, 1'b0);
    look(12'd7, 48'h1234_0ABC, "R3");
    look(12'd8, 48'h1234_0ABC, "R3");
    look(12'd9, 48'h1234_0ABC, "R3");

    // R7: twenty distinct fills into sixteen slots
    do_reset();
    for (int i = 0; i < 20; i++) fill(12'd1, 36'd100 + 36'(i), 40'd900 + 40'(i), 4'(i), 2'b00, 1'b0);
    for (int i = 0; i < 20; i++) look(12'd1, (48'd100 + 48'(i)) << 12, "R7");

    // R6: overwrite an existing key, then allocate one more
    fill(12'd1, 36'd119, 40'hCAFE, 4'hF, 2'b00, 1'b0);
    fill(12'd1, 36'd150, 40'hBEEF, 4'hE, 2'b00, 1'b0);
    for (int i = 0; i < 20; i++) look(12'd1, (48'd100 + 48'(i)) << 12, "R6");
    look(12'd1, 48'd150 << 12, "R6");

    // R12 and R8: 2 MiB page with 4 KiB pages inside it
    do_reset();
    fill(12'd1, 36'h200, 40'h7_0000, 4'h3, 2'b01, 1'b0);
    fill(12'd0, 36'h205, 40'h1_1111, 4'h5, 2'b00, 1'b1);
    fill(12'd2, 36'h205, 40'h2_2222, 4'h6, 2'b00, 1'b0);
    fill(12'd1, 36'h400, 40'h3_3333, 4'h7, 2'b00, 1'b0);
    look(12'd1, 48'h205_123, "R12");
    look(12'd2, 48'h205_123, "R12");
    look(12'd2, 48'h206_000, "R12");
    maint(2'b01, 48'h205_123);
    look(12'd1, 48'h205_123, "R8");
    look(12'd2, 48'h205_123, "R8");
    look(12'd5, 48'h205_123, "R8");
    look(12'd1, 48'h400_010, "R8");

    // R12 reverse order: 4 KiB entry filled first wins
    do_reset();
    fill(12'd1, 36'h205, 40'h1_1111, 4'h5, 2'b00, 1'b0);
    fill(12'd1, 36'h200, 40'h7_0000, 4'h3, 2'b01, 1'b0);
    look(12'd1, 48'h205_777, "R12");
    look(12'd1, 48'h201_777, "R12");

    // R9: context flush keeps globals; R9 no-op command
    do_reset();
    for (int i = 0; i < 8; i++) fill(12'(i), 36'(i) << 4, 40'(i) + 40'h100, 4'(i), 2'b00, i[0]);
    maint(2'b00, 48'h0);
    for (int i = 0; i < 8; i++) look(12'(i), 48'(i) << 16, "R9");
    maint(2'b10, 48'h0);
    for (int i = 0; i < 8; i++) look(12'(i), 48'(i) << 16, "R9");

    // R10: flush all
    maint(2'b11, 48'h0);
    for (int i = 0; i < 8; i++) look(12'(i), 48'(i) << 16, "R10");

    // R11: lookup with same-cycle page invalidate; fill with same-cycle flush all
    fill(12'd3, 36'h55, 40'h66, 4'h9, 2'b00, 1'b0);
    fill(12'd3, 36'h56, 40'h67, 4'h8, 2'b00, 1'b0);
    @(negedge clk);
    s_lv = 1; s_la = 12'd3; s_lva = 48'h55_010;
    s_mv = 1; s_mcmd = 2'b01; s_mva = 48'h55_fff;
    step("R11");
    look(12'd3, 48'h56_010, "R11");
    @(negedge clk);
    s_mv = 1; s_mcmd = 2'b11; s_mva = 48'h0;
    set_fill(12'd4, 36'h77, 40'h88, 4'h4, 2'b00, 1'b0);
    step("R11");
    look(12'd4, 48'h77_000, "R11");
    look(12'd3, 48'h56_010, "R11");

    // R13: lookup in the fill cycle sees old contents
    @(negedge clk);
    s_lv = 1; s_la = 12'd9; s_lva = 48'h99_004;
    set_fill(12'd9, 36'h99, 40'hABC, 4'hA, 2'b00, 1'b0);
    step("R13");
    look(12'd9, 48'h99_004, "R13");

    finish_run();
  end

endmodule